// File: doc/BRIEF.md
# Synchronous Cascadable Counter Stage

A four-bit binary up-counter slice whose every state change happens on the rising clock edge. On each edge the slice does exactly one of four things. It can zero itself, take a new value from a parallel data bus, advance by one, or keep its value. Which of these it does is set by a fixed priority among the control pins. No control pin reaches the register other than through the clock, so a pulse between edges has no effect until the next edge.

Counting needs two enables. The local enable gates counting only. The chain enable gates counting and also qualifies the carry output. The carry output is high while the count sits at all-ones and the chain enable is high. To build a wider counter, drive the chain enable of each stage from the carry output of the stage below. Tie all clear pins together. The stages then form one synchronous counter with no extra gates. All pins are plain level controls, and there is no streaming handshake.

Top module: `casc_counter_stage`

## Requirements
- R1: Clear, load and count take effect only at a rising clock edge; changing a control pin between edges leaves `count_q` unchanged until the next edge.
- R2: With `clear_n` low at an edge, `count_q` becomes 0 after that edge, whatever the other inputs are.
- R3: With `clear_n` high and `load_n` low at an edge, `count_q` takes `load_val` after that edge, bit 3 being the most significant.
- R4: With `clear_n` and `load_n` both high and both `en_local` and `en_chain` high, `count_q` rises by one at the edge.
- R5: With `clear_n` and `load_n` both high and either enable low, `count_q` keeps its value across the edge.
- R6: A count from 15 yields 0 (sequence 12, 13, 14, 15, 0, 1).
- R7: `carry_out` is high exactly when `count_q` is 15 and `en_chain` is high; `en_local` has no effect on it.
- R8: Two stages in cascade (upper chain enable driven by the lower carry output) form an 8-bit counter whose upper stage advances exactly once per 16 counts of the lower one.
- R9: A low `load_n` is ignored while `clear_n` is low; the result is 0, not `load_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 4 | Value taken on load |
| en_local | input | 1 | Count enable that does not gate the carry |
| en_chain | input | 1 | Count enable that also gates the carry |
| count_q | output | 4 | Current count |
| carry_out | output | 1 | High while the count is 15 and `en_chain` is high |

## Verification
Clear, load, count and hold are all registered, so each one shows on `count_q` one edge after the inputs are applied. The bench drives the inputs just after an edge and samples one nanosecond after the next edge. `carry_out` is combinational from `count_q` and `en_chain`, so it is checked in that same sample window against the inputs then applied. For R1, `clear_n` is pulled low in mid-cycle and `count_q` is sampled before the edge, where it must still hold the old value. In the cascade, the combined value is compared against the number of counting edges after every edge.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  typedef enum logic [1:0] {
    ACT_ZERO  = 2'd0,
    ACT_TAKE  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_KEEP  = 2'd3
  } stage_act_e;

  function automatic stage_act_e pick_action(
    input logic clr_n,
    input logic ld_n,
    input logic en_a,
    input logic en_b
  );
    if (!clr_n)            return ACT_ZERO;
    else if (!ld_n)        return ACT_TAKE;
    else if (en_a && en_b) return ACT_STEP;
    else                   return ACT_KEEP;
  endfunction

endpackage

// File: rtl/casc_counter_decode.sv
module casc_counter_decode
  import casc_counter_pkg::*;
(
  input  logic       clear_n,
  input  logic       load_n,
  input  logic       en_local,
  input  logic       en_chain,
  output stage_act_e action
);
  always_comb begin
    action = pick_action(clear_n, load_n, en_local, en_chain);
  end
endmodule

// File: rtl/casc_counter_incr.sv
module casc_counter_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH:0] flip;

  assign flip[0] = 1'b1;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign flip[b+1] = flip[b] & cur[b];
      assign nxt[b]    = cur[b] ^ flip[b];
    end
  endgenerate
endmodule

// File: rtl/casc_counter_reg.sv
module casc_counter_reg
  import casc_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  stage_act_e       action,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] step_val,
  output logic [WIDTH-1:0] state_q
);
  always_ff @(posedge clk) begin
    case (action)
      ACT_ZERO: state_q <= '0;
      ACT_TAKE: state_q <= load_val;
      ACT_STEP: state_q <= step_val;
      default:  state_q <= state_q;
    endcase
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clear_n;

  // R2
  zero_after_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    !$past(clear_n) |-> state_q == '0);

  // R3
  take_load_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(clear_n) && !$past(load_n)) |-> state_q == $past(load_val));

  // R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(clear_n) && $past(load_n) && $past(en_local) && $past(en_chain))
      |-> state_q == WIDTH'($past(state_q) + 1'b1));

  // R5
  keep_when_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(clear_n) && $past(load_n) && !($past(en_local) && $past(en_chain)))
      |-> $stable(state_q));
endmodule

// File: rtl/casc_counter_carry.sv
module casc_counter_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_q,
  input  logic             en_chain,
  output logic             carry_out
);
  assign carry_out = en_chain & (&state_q);
endmodule

// File: rtl/casc_counter_stage.sv
module casc_counter_stage
  import casc_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en_local,
  input  logic             en_chain,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_out
);
  stage_act_e       action;
  logic [WIDTH-1:0] step_val;

  casc_counter_decode u_decode (
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_local(en_local),
    .en_chain(en_chain),
    .action  (action)
  );

  casc_counter_incr #(.WIDTH(WIDTH)) u_incr (
    .cur(count_q),
    .nxt(step_val)
  );

  casc_counter_reg #(.WIDTH(WIDTH)) u_reg (
    .clk     (clk),
    .action  (action),
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_local(en_local),
    .en_chain(en_chain),
    .load_val(load_val),
    .step_val(step_val),
    .state_q (count_q)
  );

  casc_counter_carry #(.WIDTH(WIDTH)) u_carry (
    .state_q  (count_q),
    .en_chain (en_chain),
    .carry_out(carry_out)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clear_n;

  // R6
  wrap_after_carry_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(carry_out) && $past(en_local) && $past(clear_n) && $past(load_n))
      |-> count_q == '0);

  // R9
  clear_beats_load_chk: assert property (@(posedge clk) disable iff (!armed)
    (!$past(clear_n) && !$past(load_n)) |-> count_q == '0);
endmodule

// File: tb/casc_counter_stage_tb.sv
module casc_counter_stage_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       clear_n = 1'b1, load_n = 1'b1, en_local = 1'b0, en_chain = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count_q;
  logic       carry_out;

  casc_counter_stage dut_i (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .load_val(load_val),
    .en_local(en_local), .en_chain(en_chain),
    .count_q(count_q), .carry_out(carry_out)
  );

  logic       c_clear_n = 1'b1, c_run = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  casc_counter_stage lo_i (
    .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .load_val(4'd0),
    .en_local(1'b1), .en_chain(c_run), .count_q(lo_q), .carry_out(lo_co)
  );
  casc_counter_stage hi_i (
    .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .load_val(4'd0),
    .en_local(1'b1), .en_chain(lo_co), .count_q(hi_q), .carry_out(hi_co)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {clear_n, load_n, load_val[3:0], en_local, en_chain, exp_q[3:0], exp_carry}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_1_0000_0_0_0000_0, // R2 clear from unknown
    13'b1_0_1100_0_1_1100_0, // R3 load 12
    13'b1_1_0000_1_1_1101_0, // R4 13
    13'b1_1_0000_1_1_1110_0, // R4 14
    13'b1_1_0000_1_1_1111_1, // R4 15, R7 carry
    13'b1_1_0000_0_1_1111_1, // R5 hold, R7 carry without en_local
    13'b1_1_0000_1_0_1111_0, // R5 hold, R7 no carry without en_chain
    13'b1_1_0000_1_1_0000_0, // R6 wrap
    13'b1_1_0000_1_1_0001_0, // R6 1
    13'b0_0_1010_1_1_0000_0, // R9 clear over load
    13'b1_0_0101_1_1_0101_0, // R3 load over count
    13'b1_0_1111_0_1_1111_1, // R3 load 15, R7
    13'b0_1_0000_1_1_0000_0, // R2 clear over count
    13'b1_1_0000_0_0_0000_0  // R5 hold at 0
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    for (int i = 0; i < NV; i++) begin
      {clear_n, load_n, load_val, en_local, en_chain} = VEC[i][12:5];
      @(posedge clk); #1;
      chk($sformatf("R2-R9 vec%0d count_q", i), count_q, VEC[i][4:1]);
      chk($sformatf("R7 vec%0d carry_out", i), carry_out, VEC[i][0]);
    end

    // R1: a mid-cycle clear does not act before the edge
    clear_n = 1'b1; load_n = 1'b0; load_val = 4'd9; en_local = 1'b0; en_chain = 1'b0;
    @(posedge clk); #1;
    load_n = 1'b1;
    #3 clear_n = 1'b0;
    #1 chk("R1 no change before edge", count_q, 9);
    @(posedge clk); #1;
    chk("R1 clear at edge", count_q, 0);
    clear_n = 1'b1;

    // R7: carry follows en_chain combinationally at 15
    load_n = 1'b0; load_val = 4'd15;
    @(posedge clk); #1;
    load_n = 1'b1; en_chain = 1'b1; en_local = 1'b0;
    #1 chk("R7 carry with chain high", carry_out, 1);
    en_chain = 1'b0;
    #1 chk("R7 carry with chain low", carry_out, 0);

    // R8: two-stage cascade
    c_clear_n = 1'b0;
    @(posedge clk); #1;
    c_clear_n = 1'b1; c_run = 1'b1;
    chk("R8 cascade cleared", {hi_q, lo_q}, 0);
    begin
      int hi_steps = 0;
      for (int n = 1; n <= 300; n++) begin
        logic [3:0] prev_hi, prev_lo;
        prev_hi = hi_q; prev_lo = lo_q;
        @(posedge clk); #1;
        if (hi_q != prev_hi) begin
          hi_steps++;
          chk("R8 upper steps only after lower 15", prev_lo, 15);
        end
        chk("R8 cascade value", {hi_q, lo_q}, n % 256);
      end
      chk("R8 upper step count", hi_steps, 18);
    end
    c_run = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule